// File: doc/BRIEF.md
# Best Five-of-Seven Hand Evaluator

This block takes one player's two private cards and the five shared table cards. It returns the strength of the best five-card poker hand that can be formed from those seven cards. All 21 five-card subsets are examined. The subsets are not given to 21 separate rankers. Instead, one combinational hand ranker is time-shared and is given one candidate hand per clock. Each candidate is built from the five table cards with zero, one or two of the private cards placed into table positions.

A transaction starts when `in_valid` and `in_ready` are both high. On that edge the seven cards are captured, and the block then walks the candidates in a fixed order:

- first the table-only hand,
- then every single substitution (each private card into each table position),
- then every double substitution (both private cards into each pair of table positions).

Two running maxima are kept: one for the base and single-substitution candidates, one for the double-substitution candidates. The result is the larger of the two. It is held on the output until the consumer takes it. The block is meant to sit as one stage of a stallable simulation pipeline.

The control machine has three states:

- **INIT** (idle, ready for cards). INIT→CALC on accept.
- **CALC** (one candidate per clock). CALC→DONE after the last candidate.
- **DONE** (result valid). DONE→INIT when `out_ready` is high.

Top module: `best_hand_eval`

## Requirements
- R1: `in_ready` is high only in INIT. A transaction is accepted on a clock edge where `in_valid` and `in_ready` are both high, and the cards present on that edge are captured.
- R2: `out_valid` rises exactly 21 clock edges after the accepting edge. `in_ready` stays low from the accept until the result has been taken.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_rank` does not change. The edge with both high returns the block to INIT, so `in_ready` is high in the next cycle.
- R4: `out_rank` equals the maximum rank over all 21 five-card subsets of the seven cards, including the subset of the five table cards alone.
- R5: Card encoding. Each card is 6 bits: bits [5:2] hold the face value 0..12 (two up to ace) and bits [1:0] hold the suit. Private card i sits at `in_hole[6*i +: 6]` and table card i at `in_board[6*i +: 6]`.
- R6: Rank format. Bits [23:20] hold the hand class and bits [19:0] hold five 4-bit value fields, with field 0 at [19:16]. The class codes are: high card 0, one pair 1, two pair 2, three of a kind 3, straight 4, flush 5, full house 6, four of a kind 7, straight flush 8. A larger unsigned rank is a better hand.
- R7: For classes other than straights, the five fields list the card values ordered by multiplicity (descending), then by value (descending). A card appears once per copy.
- R8: For a straight or straight flush, field 0 is the highest card value and the other fields are zero. The sequence ace-2-3-4-5 is a five-high straight, so field 0 is 3.
- R9: When the best hand uses exactly one private card, that hand is the one reported.
- R10: When the best hand needs both private cards, that hand is the one reported.
- R11: Input card values and `in_valid` pulses that arrive while the block is busy have no effect on the result in progress.
- R12: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Card set offered |
| in_ready | output | 1 | Block is idle and accepts cards |
| in_hole | input | 12 | Two private cards, 6 bits each |
| in_board | input | 30 | Five table cards, 6 bits each |
| out_valid | output | 1 | Best rank available |
| out_ready | input | 1 | Consumer takes the rank |
| out_rank | output | 24 | Best five-card rank |

## Verification
The bench builds the block with its default parameters: two private cards, five table cards, 4-bit value fields, a 4-bit class field and therefore 21 candidates. With these values the full candidate walk is exercised, so every index in the substitution table and the exact 21-cycle latency are reached. Directed deals force the best hand to come from:

- the table alone,
- a single substitution,
- a double substitution,
- the ace-low straight,
- a royal flush,
- a full house,
- four of a kind.

Random deals combine random consumer stalls with garbage inputs driven during the calculation.

// File: rtl/poker_eval_pkg.sv
package poker_eval_pkg;

    localparam int VAL_W   = 4;
    localparam int SUIT_W  = 2;
    localparam int CARD_W  = VAL_W + SUIT_W;
    localparam int HAND_N  = 5;
    localparam int TYPE_W  = 4;
    localparam int RANK_W  = TYPE_W + HAND_N * VAL_W;
    localparam int KEY_W   = 3 + VAL_W;

    typedef logic [CARD_W-1:0]             card_t;
    typedef logic [HAND_N-1:0][CARD_W-1:0] hand_t;
    typedef logic [RANK_W-1:0]             rank_t;

    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_CALC = 2'd1,
        ST_DONE = 2'd2
    } eval_state_e;

    // Replace one table slot with a private card.
    function automatic hand_t swap_one(hand_t base, card_t c, int pos);
        hand_t r;
        r = base;
        r[pos] = c;
        return r;
    endfunction

    // Replace two table slots with both private cards.
    function automatic hand_t swap_two(hand_t base, card_t c0, card_t c1, int p0, int p1);
        hand_t r;
        r = base;
        r[p0] = c0;
        r[p1] = c1;
        return r;
    endfunction

    // Combinational five-card ranker.
    function automatic rank_t rank_hand(hand_t h);
        logic [VAL_W-1:0]  v [HAND_N];
        logic [2:0]        c [HAND_N];
        logic [KEY_W-1:0]  k [HAND_N];
        logic [KEY_W-1:0]  t;
        logic              flush, distinct, run, wheel, strt;
        logic [TYPE_W-1:0] ty;
        logic [VAL_W-1:0]  top;

        for (int i = 0; i < HAND_N; i++) begin
            v[i] = h[i][CARD_W-1:SUIT_W];
        end

        // Multiplicity of each card's value within the hand.
        for (int i = 0; i < HAND_N; i++) begin
            c[i] = 3'd0;
            for (int j = 0; j < HAND_N; j++) begin
                if (v[j] == v[i]) begin
                    c[i] = c[i] + 3'd1;
                end
            end
            k[i] = {c[i], v[i]};
        end

        // Sort keys {multiplicity, value} descending.
        for (int a = 0; a < HAND_N - 1; a++) begin
            for (int b = 0; b < HAND_N - 1 - a; b++) begin
                if (k[b] < k[b+1]) begin
                    t      = k[b];
                    k[b]   = k[b+1];
                    k[b+1] = t;
                end
            end
        end

        flush = 1'b1;
        for (int i = 1; i < HAND_N; i++) begin
            if (h[i][SUIT_W-1:0] != h[0][SUIT_W-1:0]) begin
                flush = 1'b0;
            end
        end

        distinct = (k[0][KEY_W-1:VAL_W] == 3'd1);
        run      = distinct && ((k[0][VAL_W-1:0] - k[HAND_N-1][VAL_W-1:0]) == VAL_W'(4));
        wheel    = distinct && (k[0][VAL_W-1:0] == VAL_W'(12)) && (k[1][VAL_W-1:0] == VAL_W'(3));
        strt     = run || wheel;
        top      = wheel ? VAL_W'(3) : k[0][VAL_W-1:0];

        if (strt && flush)                                                  ty = TYPE_W'(8);
        else if (k[0][KEY_W-1:VAL_W] == 3'd4)                               ty = TYPE_W'(7);
        else if (k[0][KEY_W-1:VAL_W] == 3'd3 && k[3][KEY_W-1:VAL_W] == 3'd2) ty = TYPE_W'(6);
        else if (flush)                                                     ty = TYPE_W'(5);
        else if (strt)                                                      ty = TYPE_W'(4);
        else if (k[0][KEY_W-1:VAL_W] == 3'd3)                               ty = TYPE_W'(3);
        else if (k[0][KEY_W-1:VAL_W] == 3'd2 && k[2][KEY_W-1:VAL_W] == 3'd2) ty = TYPE_W'(2);
        else if (k[0][KEY_W-1:VAL_W] == 3'd2)                               ty = TYPE_W'(1);
        else                                                                ty = TYPE_W'(0);

        if (strt) begin
            return {ty, top, {((HAND_N-1)*VAL_W){1'b0}}};
        end
        return {ty, k[0][VAL_W-1:0], k[1][VAL_W-1:0], k[2][VAL_W-1:0],
                k[3][VAL_W-1:0], k[4][VAL_W-1:0]};
    endfunction

endpackage

// File: rtl/bes_ctrl.sv
module bes_ctrl
    import poker_eval_pkg::*;
#(
    parameter int NUM_CAND = 21,
    parameter int IDX_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             capture,
    output logic             step,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CAND - 1);

    eval_state_e state, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_INIT;
        end else begin
            state <= state_n;
        end
    end

    // Transitions: INIT->CALC on accept, CALC->DONE on last candidate, DONE->INIT on take.
    always_comb begin
        state_n = state;
        unique case (state)
            ST_INIT: if (in_valid)         state_n = ST_CALC;
            ST_CALC: if (idx == LAST_IDX)  state_n = ST_DONE;
            ST_DONE: if (out_ready)        state_n = ST_INIT;
            default:                       state_n = ST_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (state == ST_CALC) begin
            idx <= idx + IDX_W'(1);
        end else begin
            idx <= '0;
        end
    end

    always_comb begin
        in_ready  = (state == ST_INIT);
        out_valid = (state == ST_DONE);
        capture   = (state == ST_INIT) && in_valid;
        step      = (state == ST_CALC);
    end

endmodule

// File: rtl/bes_cand_gen.sv
module bes_cand_gen
    import poker_eval_pkg::*;
#(
    parameter int HOLE_N   = 2,
    parameter int BOARD_N  = 5,
    parameter int NUM_CAND = 21,
    parameter int IDX_W    = 5
) (
    input  logic [HOLE_N-1:0][CARD_W-1:0] hole,
    input  hand_t                         board,
    input  logic [IDX_W-1:0]              idx,
    output hand_t                         cand,
    output logic                          is_double
);

    localparam int SINGLE_BASE = 1;
    localparam int DOUBLE_BASE = 1 + HOLE_N * BOARD_N;

    hand_t tbl [NUM_CAND];

    assign tbl[0] = board;

    for (genvar h = 0; h < HOLE_N; h++) begin : g_hole
        for (genvar p = 0; p < BOARD_N; p++) begin : g_pos
            assign tbl[SINGLE_BASE + h*BOARD_N + p] = swap_one(board, hole[h], p);
        end
    end

    for (genvar i = 0; i < BOARD_N; i++) begin : g_pa
        for (genvar j = i + 1; j < BOARD_N; j++) begin : g_pb
            localparam int PIDX = i*BOARD_N - (i*(i+1))/2 + (j - i - 1);
            assign tbl[DOUBLE_BASE + PIDX] = swap_two(board, hole[0], hole[1], i, j);
        end
    end

    assign cand      = (int'(idx) < NUM_CAND) ? tbl[idx] : tbl[0];
    assign is_double = (int'(idx) >= DOUBLE_BASE);

endmodule

// File: rtl/bes_ranker.sv
module bes_ranker
    import poker_eval_pkg::*;
(
    input  hand_t hand,
    output rank_t rank
);

    assign rank = rank_hand(hand);

endmodule

// File: rtl/bes_maxtrack.sv
module bes_maxtrack
    import poker_eval_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear,
    input  logic  step,
    input  logic  is_double,
    input  rank_t rank,
    output rank_t best
);

    rank_t best_single, best_double;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_single <= '0;
            best_double <= '0;
        end else if (clear) begin
            best_single <= '0;
            best_double <= '0;
        end else if (step) begin
            if (is_double) begin
                if (rank > best_double) best_double <= rank;
            end else begin
                if (rank > best_single) best_single <= rank;
            end
        end
    end

    assign best = (best_single > best_double) ? best_single : best_double;

endmodule

// File: rtl/best_hand_eval.sv
module best_hand_eval
    import poker_eval_pkg::*;
#(
    parameter int HOLE_N  = 2,
    parameter int BOARD_N = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [HOLE_N*CARD_W-1:0]    in_hole,
    input  logic [BOARD_N*CARD_W-1:0]   in_board,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [RANK_W-1:0]           out_rank
);

    localparam int NUM_CAND = 1 + HOLE_N*BOARD_N + (BOARD_N*(BOARD_N-1))/2;
    localparam int IDX_W    = $clog2(NUM_CAND);

    logic                          capture, step, is_double;
    logic [IDX_W-1:0]              idx;
    logic [HOLE_N-1:0][CARD_W-1:0] hole_q;
    hand_t                         board_q, cand;
    rank_t                         cand_rank;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hole_q  <= '0;
            board_q <= '0;
        end else if (capture) begin
            hole_q  <= in_hole;
            board_q <= in_board;
        end
    end

    bes_ctrl #(.NUM_CAND(NUM_CAND), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .capture   (capture),
        .step      (step),
        .idx       (idx)
    );

    bes_cand_gen #(.HOLE_N(HOLE_N), .BOARD_N(BOARD_N), .NUM_CAND(NUM_CAND), .IDX_W(IDX_W)) u_cand (
        .hole      (hole_q),
        .board     (board_q),
        .idx       (idx),
        .cand      (cand),
        .is_double (is_double)
    );

    bes_ranker u_rank (
        .hand (cand),
        .rank (cand_rank)
    );

    bes_maxtrack u_max (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (capture),
        .step      (step),
        .is_double (is_double),
        .rank      (cand_rank),
        .best      (out_rank)
    );

endmodule

// File: rtl/bes_chk.sv
module bes_chk #(
    parameter int NUM_CAND = 21,
    parameter int RANK_W   = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [RANK_W-1:0] out_rank
);

    logic        busy;
    logic [15:0] lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            lat  <= '0;
        end else if (in_valid && in_ready) begin
            busy <= 1'b1;
            lat  <= '0;
        end else if (busy && !out_valid) begin
            lat <= lat + 16'd1;
        end else if (out_valid) begin
            busy <= 1'b0;
        end
    end

    assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (busy && lat == 16'(NUM_CAND)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_rank)));

    assert_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> in_ready);

    assert_class_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_rank[RANK_W-1 -: 4] <= 4'd8));

endmodule

bind best_hand_eval bes_chk #(.NUM_CAND(NUM_CAND), .RANK_W(poker_eval_pkg::RANK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_rank  (out_rank)
);

// File: tb/best_hand_eval_tb.sv
`timescale 1ns/1ps
module best_hand_eval_tb;

    localparam int NDIR  = 7;
    localparam int NRAND = 40;
    localparam int NH    = NDIR + NRAND;
    localparam int NCAND = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] in_hole = '0;
    logic [29:0] in_board = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [23:0] out_rank;

    always #5 clk = ~clk;

    best_hand_eval u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_hole(in_hole), .in_board(in_board), .out_valid(out_valid),
        .out_ready(out_ready), .out_rank(out_rank)
    );

    int errors = 0;
    int checks = 0;

    int    hands [NH][7];
    string tags  [NH];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [5:0] cbits(input int c);
        return {4'(c % 13), 2'(c / 13)};
    endfunction

    function automatic int mk(input int v, input int s);
        return s * 13 + v;
    endfunction

    // Behavioural five-card rank from a value histogram.
    function automatic logic [23:0] ref_rank(input int cs[5]);
        int hist[13];
        int f[5];
        int n, ndist, maxm, npair, mx, mn;
        bit flush, strt, wheel;
        int ty, top;
        for (int v = 0; v < 13; v++) hist[v] = 0;
        for (int i = 0; i < 5; i++) hist[cs[i] % 13]++;
        n = 0;
        for (int m = 4; m >= 1; m--)
            for (int v = 12; v >= 0; v--)
                if (hist[v] == m)
                    for (int r = 0; r < m; r++) begin f[n] = v; n++; end
        ndist = 0; maxm = 0; npair = 0; mx = 0; mn = 12;
        for (int v = 0; v < 13; v++) begin
            if (hist[v] > 0) begin
                ndist++;
                if (v > mx) mx = v;
                if (v < mn) mn = v;
            end
            if (hist[v] > maxm) maxm = hist[v];
            if (hist[v] == 2) npair++;
        end
        flush = 1;
        for (int i = 1; i < 5; i++) if (cs[i] / 13 != cs[0] / 13) flush = 0;
        wheel = (ndist == 5) && hist[12] > 0 && hist[0] > 0 && hist[1] > 0 && hist[2] > 0 && hist[3] > 0;
        strt  = ((ndist == 5) && (mx - mn == 4)) || wheel;
        top   = wheel ? 3 : mx;
        if (strt && flush)              ty = 8;
        else if (maxm == 4)             ty = 7;
        else if (maxm == 3 && npair==1) ty = 6;
        else if (flush)                 ty = 5;
        else if (strt)                  ty = 4;
        else if (maxm == 3)             ty = 3;
        else if (npair == 2)            ty = 2;
        else if (npair == 1)            ty = 1;
        else                            ty = 0;
        if (strt) return {4'(ty), 4'(top), 16'h0};
        return {4'(ty), 4'(f[0]), 4'(f[1]), 4'(f[2]), 4'(f[3]), 4'(f[4])};
    endfunction

    // Best over every 5-of-7 subset, enumerated by bit mask.
    function automatic logic [23:0] ref_best(input int h[7]);
        logic [23:0] best, r;
        int sub[5];
        int n;
        best = '0;
        for (int m = 0; m < 128; m++) begin
            if ($countones(m) == 5) begin
                n = 0;
                for (int b = 0; b < 7; b++) if (m[b]) begin sub[n] = h[b]; n++; end
                r = ref_rank(sub);
                if (r > best) best = r;
            end
        end
        return best;
    endfunction

    initial begin
        int deck[52];
        int ph, cnt, hi, cyc;
        logic [23:0] exp_rank;
        string cur_tag;
        int tmp, jj;

        // Card order per hand: hole0, hole1, board0..board4.
        hands[0] = '{mk(12,0), mk(7,1),  mk(0,2),  mk(1,3),  mk(2,0),  mk(3,1),  mk(11,2)}; tags[0] = "R8";
        hands[1] = '{mk(11,0), mk(1,1),  mk(11,1), mk(0,2),  mk(3,3),  mk(6,0),  mk(9,1)};  tags[1] = "R9";
        hands[2] = '{mk(10,0), mk(10,1), mk(0,2),  mk(3,3),  mk(6,0),  mk(9,1),  mk(1,2)};  tags[2] = "R10";
        hands[3] = '{mk(3,0),  mk(4,1),  mk(0,2),  mk(4,2),  mk(7,2),  mk(9,2),  mk(11,2)}; tags[3] = "R4";
        hands[4] = '{mk(5,0),  mk(5,1),  mk(5,2),  mk(11,0), mk(11,1), mk(0,3),  mk(7,2)};  tags[4] = "R7";
        hands[5] = '{mk(8,3),  mk(9,3),  mk(10,3), mk(11,3), mk(12,3), mk(0,0),  mk(12,1)}; tags[5] = "R6";
        hands[6] = '{mk(12,0), mk(0,0),  mk(12,1), mk(12,2), mk(12,3), mk(1,1),  mk(3,2)};  tags[6] = "R5";
        for (int h = NDIR; h < NH; h++) begin
            for (int i = 0; i < 52; i++) deck[i] = i;
            for (int i = 0; i < 7; i++) begin
                jj = i + int'($urandom % (52 - i));
                tmp = deck[i]; deck[i] = deck[jj]; deck[jj] = tmp;
                hands[h][i] = deck[i];
            end
            tags[h] = "R11";
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(in_ready === 1'b1, "R12", "in_ready in reset", in_ready, 1);
        chk(out_valid === 1'b0, "R12", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;

        ph = 0; cnt = 0; hi = 0; cyc = 0; exp_rank = '0; cur_tag = "";
        while (!(hi == NH && ph == 0) && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            chk(in_ready === (ph == 0), "R1", "in_ready", in_ready, (ph == 0));
            chk(out_valid === (ph == 2), "R2", "out_valid", out_valid, (ph == 2));
            if (ph == 2)
                chk(out_rank === exp_rank, cur_tag, "out_rank (R3 hold)", out_rank, exp_rank);

            out_ready = ($urandom % 3) != 0;
            if (ph == 0) begin
                if (hi < NH && ($urandom % 4) != 0) begin
                    in_valid = 1'b1;
                    in_hole  = {cbits(hands[hi][1]), cbits(hands[hi][0])};
                    in_board = {cbits(hands[hi][6]), cbits(hands[hi][5]), cbits(hands[hi][4]),
                                cbits(hands[hi][3]), cbits(hands[hi][2])};
                    exp_rank = ref_best(hands[hi]);
                    cur_tag  = tags[hi];
                    hi++;
                    ph = 1; cnt = 0;
                end else begin
                    in_valid = 1'b0;
                end
            end else begin
                in_valid = 1'($urandom % 2);
                in_hole  = 12'($urandom);
                in_board = 30'($urandom);
                if (ph == 1) begin
                    cnt++;
                    if (cnt == NCAND) ph = 2;
                end else if (out_ready) begin
                    ph = 0;
                end
            end
        end
        if (cyc >= 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule